// File: doc/BRIEF.md
# Dual-Clock Valid/Ready Stream FIFO

This block moves one valid/ready stream from a source clock domain into a destination clock domain whose clock has no known relation to the source clock. Every beat is packed into a single storage word, so all of its fields cross together and cannot skew against each other. The storage is a dual-clock array. Each side keeps its own binary pointer, which is also kept in Gray code. The Gray pointer is carried to the other side through a two-flop synchronizer. The payload itself never passes through a synchronizer: an entry is read only after its pointer shows that it has been written.

Each side sees an ordinary handshake. On the source side, ready is the inverse of the full flag. On the destination side, valid is the inverse of the empty flag, and the entry at the read pointer is shown directly as first-word-fall-through data. Each side has a small state machine that holds its flag:
- Write side: states `WR_OPEN` and `WR_BLOCKED`. The *fill* transition goes from OPEN to BLOCKED when the next write pointer meets the synchronized read pointer with its two top bits inverted. The *release* transition goes back when that condition clears.
- Read side: states `RD_DRY` and `RD_PRESENT`. The *arrive* transition goes from DRY to PRESENT when the next read Gray pointer differs from the synchronized write Gray pointer. The *drain* transition goes back when they match.

Each side has its own active-low asynchronous reset. The depth is 2**ADDR_W, and ADDR_W must be at least 2. Both flags are conservative: a flag can stay set for a few cycles after space or data has actually appeared.

Top module: `xdom_stream_fifo`

## Requirements
- R1: While src_rst_n and dst_rst_n are low, src_ready is 1 and dst_valid is 0.
- R2: A beat is stored only at a source edge where src_valid and src_ready are both 1. If the destination never takes a beat, exactly 2**ADDR_W beats are accepted and src_ready then stays 0.
- R3: src_ready stays 0 while the FIFO is full. After one beat is consumed, src_ready returns to 1 within 8 source cycles.
- R4: dst_valid is 1 whenever at least one stored beat is unread. Once every stored beat has been consumed, dst_valid returns to 0 and stays 0.
- R5: dst_ready while dst_valid is 0 has no effect. It consumes nothing, and the next beat written afterwards is still delivered.
- R6: While dst_valid is 1 and dst_ready is 0, dst_data holds its value.
- R7: All DATA_W bits of every accepted beat are delivered exactly once and in acceptance order. This holds when the destination clock is faster than, slower than or equal to the source clock, with random stalls on both sides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source-domain clock |
| src_rst_n | input | 1 | Source-domain asynchronous reset, active low |
| src_valid | input | 1 | Source offers a beat |
| src_ready | output | 1 | FIFO can take a beat (not full) |
| src_data | input | DATA_W | Packed beat payload |
| dst_clk | input | 1 | Destination-domain clock |
| dst_rst_n | input | 1 | Destination-domain asynchronous reset, active low |
| dst_valid | output | 1 | A beat is presented (not empty) |
| dst_ready | input | 1 | Destination takes the presented beat |
| dst_data | output | DATA_W | Payload of the oldest unread beat |

## Verification
src_ready falls at the same source edge that stores the last free entry. A new beat reaches dst_valid about three to four destination edges after its write edge. A read frees src_ready about three to four source edges after the read edge. The bench drives inputs one nanosecond after a rising edge and samples at the following falling edge. A handshake seen at that falling edge is therefore counted at the next rising edge. Checks on the cross-domain latencies poll within a bounded window, 8 source cycles for release, instead of naming a single edge. Checks that something stays idle wait about ten destination cycles before they sample.

// File: rtl/xdom_fifo_pkg.sv
package xdom_fifo_pkg;

    typedef enum logic {
        WR_OPEN    = 1'b0,
        WR_BLOCKED = 1'b1
    } wr_state_e;

    typedef enum logic {
        RD_DRY     = 1'b0,
        RD_PRESENT = 1'b1
    } rd_state_e;

endpackage

// File: rtl/xdom_sync.sv
module xdom_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/xdom_store.sv
module xdom_store #(
    parameter int DW = 32,
    parameter int AW = 3
) (
    input  logic          wclk,
    input  logic          wen,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (wen) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/xdom_wr_ctrl.sv
module xdom_wr_ctrl
    import xdom_fifo_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW:0]   rgray_sync,
    output logic          ready,
    output logic          wen,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray
);
    localparam int PW = AW + 1;

    wr_state_e     state, state_nx;
    logic [AW:0]   wbin, wbin_nx, wgray_nx, full_mark;
    logic          full_nx;

    always_comb begin
        wen       = push && (state == WR_OPEN);
        wbin_nx   = wbin + PW'(wen);
        wgray_nx  = wbin_nx ^ (wbin_nx >> 1);
        full_mark = {~rgray_sync[AW:AW-1], rgray_sync[AW-2:0]};
        full_nx   = (wgray_nx == full_mark);
        state_nx  = state;
        unique case (state)
            WR_OPEN:    if (full_nx)  state_nx = WR_BLOCKED;
            WR_BLOCKED: if (!full_nx) state_nx = WR_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WR_OPEN;
            wbin  <= '0;
            wgray <= '0;
        end else begin
            state <= state_nx;
            wbin  <= wbin_nx;
            wgray <= wgray_nx;
        end
    end

    always_comb begin
        ready = (state == WR_OPEN);
        waddr = wbin[AW-1:0];
    end
endmodule

// File: rtl/xdom_rd_ctrl.sv
module xdom_rd_ctrl
    import xdom_fifo_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic [AW:0]   wgray_sync,
    output logic          valid,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray
);
    localparam int PW = AW + 1;

    rd_state_e   state, state_nx;
    logic [AW:0] rbin, rbin_nx, rgray_nx;
    logic        ren, empty_nx;

    always_comb begin
        ren      = pop && (state == RD_PRESENT);
        rbin_nx  = rbin + PW'(ren);
        rgray_nx = rbin_nx ^ (rbin_nx >> 1);
        empty_nx = (rgray_nx == wgray_sync);
        state_nx = state;
        unique case (state)
            RD_DRY:     if (!empty_nx) state_nx = RD_PRESENT;
            RD_PRESENT: if (empty_nx)  state_nx = RD_DRY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RD_DRY;
            rbin  <= '0;
            rgray <= '0;
        end else begin
            state <= state_nx;
            rbin  <= rbin_nx;
            rgray <= rgray_nx;
        end
    end

    always_comb begin
        valid = (state == RD_PRESENT);
        raddr = rbin[AW-1:0];
    end
endmodule

// File: rtl/xdom_stream_fifo.sv
module xdom_stream_fifo #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic              src_clk,
    input  logic              src_rst_n,
    input  logic              src_valid,
    output logic              src_ready,
    input  logic [DATA_W-1:0] src_data,
    input  logic              dst_clk,
    input  logic              dst_rst_n,
    output logic              dst_valid,
    input  logic              dst_ready,
    output logic [DATA_W-1:0] dst_data
);
    localparam int PW = ADDR_W + 1;

    logic [PW-1:0]     wr_gray, rd_gray, wr_gray_q, rd_gray_q;
    logic [ADDR_W-1:0] waddr, raddr;
    logic              wen;

    xdom_wr_ctrl #(.AW(ADDR_W)) u_wr (
        .clk        (src_clk),
        .rst_n      (src_rst_n),
        .push       (src_valid),
        .rgray_sync (rd_gray_q),
        .ready      (src_ready),
        .wen        (wen),
        .waddr      (waddr),
        .wgray      (wr_gray)
    );

    xdom_sync #(.WIDTH(PW), .STAGES(2)) u_rd2wr (
        .clk   (src_clk),
        .rst_n (src_rst_n),
        .d     (rd_gray),
        .q     (rd_gray_q)
    );

    xdom_sync #(.WIDTH(PW), .STAGES(2)) u_wr2rd (
        .clk   (dst_clk),
        .rst_n (dst_rst_n),
        .d     (wr_gray),
        .q     (wr_gray_q)
    );

    xdom_store #(.DW(DATA_W), .AW(ADDR_W)) u_store (
        .wclk  (src_clk),
        .wen   (wen),
        .waddr (waddr),
        .wdata (src_data),
        .raddr (raddr),
        .rdata (dst_data)
    );

    xdom_rd_ctrl #(.AW(ADDR_W)) u_rd (
        .clk        (dst_clk),
        .rst_n      (dst_rst_n),
        .pop        (dst_ready),
        .wgray_sync (wr_gray_q),
        .valid      (dst_valid),
        .raddr      (raddr),
        .rgray      (rd_gray)
    );
endmodule

// File: rtl/xdom_fifo_chk.sv
module xdom_fifo_chk #(
    parameter int DW = 32,
    parameter int AW = 3
) (
    input logic          src_clk,
    input logic          src_rst_n,
    input logic          src_valid,
    input logic          src_ready,
    input logic [AW:0]   wr_gray,
    input logic          dst_clk,
    input logic          dst_rst_n,
    input logic          dst_valid,
    input logic          dst_ready,
    input logic [DW-1:0] dst_data,
    input logic [AW:0]   rd_gray
);
    // R1
    src_idle_chk: assert property (@(posedge src_clk) !src_rst_n |-> src_ready);

    // R1
    dst_idle_chk: assert property (@(posedge dst_clk) !dst_rst_n |-> !dst_valid);

    // R2
    no_overflow_chk: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        !src_ready |=> $stable(wr_gray));

    // R5
    no_underflow_chk: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        !dst_valid |=> $stable(rd_gray));

    // R6
    payload_hold_chk: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        (dst_valid && !dst_ready) |=> (dst_valid && $stable(dst_data)));

    // R7
    wr_gray_step_chk: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        $countones(wr_gray ^ $past(wr_gray)) <= 1);

    // R7
    rd_gray_step_chk: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        $countones(rd_gray ^ $past(rd_gray)) <= 1);
endmodule

bind xdom_stream_fifo xdom_fifo_chk #(.DW(DATA_W), .AW(ADDR_W)) u_chk (
    .src_clk   (src_clk),
    .src_rst_n (src_rst_n),
    .src_valid (src_valid),
    .src_ready (src_ready),
    .wr_gray   (wr_gray),
    .dst_clk   (dst_clk),
    .dst_rst_n (dst_rst_n),
    .dst_valid (dst_valid),
    .dst_ready (dst_ready),
    .dst_data  (dst_data),
    .rd_gray   (rd_gray)
);

// File: tb/tb_xdom_stream_fifo.sv
`timescale 1ns/1ps
module tb_xdom_stream_fifo;
    localparam int DW    = 32;
    localparam int AW    = 3;
    localparam int DEPTH = 1 << AW;

    logic          src_clk = 1'b0, dst_clk = 1'b0;
    logic          src_rst_n = 1'b1, dst_rst_n = 1'b1;
    logic          src_valid = 1'b0, dst_ready = 1'b0;
    logic [DW-1:0] src_data = '0;
    logic          src_ready, dst_valid;
    logic [DW-1:0] dst_data;
    realtime       dst_half = 10.0;
    int            checks = 0, fails = 0;

    always #10 src_clk = ~src_clk;
    initial forever #(dst_half) dst_clk = ~dst_clk;

    xdom_stream_fifo #(.DATA_W(DW), .ADDR_W(AW)) dut (
        .src_clk(src_clk), .src_rst_n(src_rst_n), .src_valid(src_valid),
        .src_ready(src_ready), .src_data(src_data),
        .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .dst_valid(dst_valid),
        .dst_ready(dst_ready), .dst_data(dst_data)
    );

    function automatic logic [DW-1:0] pattern(int k);
        logic [15:0] lo = k[15:0];
        return {lo ^ 16'hA5C3, ~lo};
    endfunction

    task automatic check(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic produce(int n, int stall, int base);
        int sent = 0;
        bit take;
        while (sent < n) begin
            if (!src_valid && ($urandom_range(99) >= stall)) begin
                src_valid = 1'b1;
                src_data  = pattern(base + sent);
            end
            @(negedge src_clk);
            take = src_valid && src_ready;
            @(posedge src_clk); #1;
            if (take) begin
                sent++;
                src_valid = 1'b0;
            end
        end
    endtask

    task automatic consume(int n, int stall, int base);
        int got = 0;
        bit holding = 0;
        logic [DW-1:0] held = '0;
        while (got < n) begin
            @(posedge dst_clk); #1;
            dst_ready = ($urandom_range(99) >= stall);
            @(negedge dst_clk);
            if (holding && dst_valid)
                check(dst_data == held, "R6 payload held", dst_data, held);
            if (dst_valid && dst_ready) begin
                check(dst_data == pattern(base + got), "R7 order/data", dst_data, pattern(base + got));
                got++;
                holding = 0;
            end else if (dst_valid) begin
                holding = 1;
                held    = dst_data;
            end
        end
        @(posedge dst_clk); #1;
        dst_ready = 1'b0;
    endtask

    task automatic settle_idle(string tag);
        repeat (12) @(posedge dst_clk);
        @(negedge dst_clk);
        check(dst_valid == 1'b0, {tag, " R4 empty after drain"}, DW'(dst_valid), '0);
        @(negedge src_clk);
        check(src_ready == 1'b1, {tag, " R3 space after drain"}, DW'(src_ready), DW'(1));
    endtask

    task automatic t_reset();
        #1;
        src_rst_n = 1'b0;
        dst_rst_n = 1'b0;
        repeat (4) @(posedge src_clk);
        @(negedge src_clk);
        check(src_ready == 1'b1, "R1 src_ready in reset", DW'(src_ready), DW'(1));
        check(dst_valid == 1'b0, "R1 dst_valid in reset", DW'(dst_valid), '0);
        src_rst_n = 1'b1;
        dst_rst_n = 1'b1;
        repeat (4) @(posedge src_clk);
    endtask

    task automatic t_fill_and_release(int base);
        int acc = 0;
        bit take;
        bit freed = 0;
        src_valid = 1'b1;
        src_data  = pattern(base);
        for (int c = 0; c < 3 * DEPTH; c++) begin
            @(negedge src_clk);
            take = src_ready;
            @(posedge src_clk); #1;
            if (take) begin
                acc++;
                src_data = pattern(base + acc);
            end
        end
        src_valid = 1'b0;
        check(acc == DEPTH, "R2 beats accepted when full", DW'(acc), DW'(DEPTH));
        @(negedge src_clk);
        check(src_ready == 1'b0, "R3 ready low while full", DW'(src_ready), '0);
        check(dst_valid == 1'b1, "R4 valid with data", DW'(dst_valid), DW'(1));
        consume(1, 0, base);
        for (int c = 0; c < 8 && !freed; c++) begin
            @(negedge src_clk);
            freed = src_ready;
        end
        check(freed, "R3 release within 8 cycles", DW'(freed), DW'(1));
        consume(DEPTH - 1, 0, base + 1);
        settle_idle("fill");
    endtask

    task automatic t_ready_on_empty(int base);
        @(posedge dst_clk); #1;
        dst_ready = 1'b1;
        for (int c = 0; c < 20; c++) begin
            @(negedge dst_clk);
            check(dst_valid == 1'b0, "R5 no beat while empty", DW'(dst_valid), '0);
        end
        @(posedge dst_clk); #1;
        dst_ready = 1'b0;
        produce(1, 0, base);
        consume(1, 0, base);
        settle_idle("empty");
    endtask

    task automatic t_stream(realtime half, int n, int stall, int base, string tag);
        dst_half = half;
        repeat (3) @(posedge src_clk);
        fork
            produce(n, stall, base);
            consume(n, stall, base);
        join
        settle_idle(tag);
    endtask

    initial begin
        repeat (150000) @(posedge src_clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_fill_and_release(100);
        t_ready_on_empty(300);
        t_stream(3.5, 200, 30, 1000, "fast dst");
        t_stream(16.5, 200, 30, 2000, "slow dst");
        t_stream(10.0, 150, 50, 3000, "equal");
        t_stream(27.0, 150, 0, 4000, "very slow dst");
        t_stream(4.5, 150, 0, 5000, "fast no stall");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule